// File: doc/BRIEF.md
# Per-Port Frame Statistics Counter Bank

This block holds the statistics counters of one switch port. The port's receive and transmit MAC logic report what they saw as single-cycle pulses. Receive pulses cover frame classes, errors, pause and MAC-control frames, and drops. Transmit pulses cover frame classes, collisions, deferrals, pause frames and drops. A completed-frame strobe with a byte length drives the size histogram and the byte totals. Each pulse adds to the matching counter in the cycle it arrives. Each counter is `CNT_W` bits wide and stops at all-ones.

Software reads a counter through a small command port. It writes a read request that carries an 8-bit index and then polls the busy flag. When the flag drops, `rd_data` holds a snapshot of the counter. The selected counter is cleared in the same clock edge that takes the snapshot, so each read returns the activity since the previous read. The index space is sparse: two dense groups at the bottom and a short group of totals at 0x80.

Top module: `stats_bank`

## Requirements
- R1: Receive event bit i (i = 0..12 of `rx_evt`) adds one to the counter at index i. The index order is high-priority, undersize, fragment, oversize, jabber, symbol error, CRC error, alignment error, MAC control, pause, broadcast, multicast, unicast.
- R2: A `rx_done` strobe adds one to exactly one size bin, chosen by `rx_len`: 0x0D for 64 or less, 0x0E for 65..127, 0x0F for 128..255, 0x10 for 256..511, 0x11 for 512..1023, 0x12 for 1024..1522, 0x13 for 1523..2000, 0x14 for 2001 and up.
- R3: Transmit event bit j (j = 0..10 of `tx_evt`) adds one to the counter at index 0x15+j. The index order is high-priority, late collision, pause, broadcast, multicast, unicast, deferred, total collisions, excessive collisions, single collision, multiple collision.
- R4: Index 0x80 adds `rx_len` on each `rx_done`. Index 0x81 adds `tx_len` on each `tx_done`. Index 0x82 counts `rx_drop` pulses and index 0x83 counts `tx_drop` pulses.
- R5: A read of any index outside 0x00..0x1F and 0x80..0x83 returns zero and changes no counter.
- R6: A cycle with `cmd_wr`=1 and `cmd_rd`=1 while `cmd_busy` is 0 raises `cmd_busy` after that edge. A command write with `cmd_rd`=0, or any command write while `cmd_busy` is 1, is ignored.
- R7: `cmd_busy` stays high for exactly one cycle. `rd_data` takes the result on the second edge, counting the command edge as the first, and holds its value at every other edge.
- R8: A completed read of a defined index resets that counter, so an immediate second read returns zero.
- R9: An increment that arrives in the snapshot cycle goes into the freshly cleared counter and is not lost.
- R10: Counters saturate at 2^CNT_W-1 and do not wrap, including when a byte total adds a large length.
- R11: After reset all counters, `cmd_busy` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_evt | input | 13 | Receive event pulses, bit i maps to index i |
| tx_evt | input | 11 | Transmit event pulses, bit j maps to index 0x15+j |
| rx_drop | input | 1 | Receive discard pulse |
| tx_drop | input | 1 | Transmit discard pulse |
| rx_done | input | 1 | Received frame complete |
| rx_len | input | LEN_W | Received frame length in bytes |
| tx_done | input | 1 | Transmitted frame complete |
| tx_len | input | LEN_W | Transmitted frame length in bytes |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_rd | input | 1 | Read-request bit of the command write |
| cmd_idx | input | 8 | Counter index of the command write |
| cmd_busy | output | 1 | Read in progress; polled by software |
| rd_data | output | CNT_W | Snapshot of the last counter read |

## Verification
The bench builds the bank with `CNT_W`=12 and `LEN_W`=11. The 11-bit length reaches every size bin, including the 2001-and-up bin. With 12-bit counters, an event counter can be driven to saturation in a few thousand cycles, and a byte total saturates after three long frames, so the R10 clamp is exercised on both increment widths. Random event traffic runs alongside reads of defined and undefined indices. Directed sequences place increments in the snapshot cycle, issue writes while a read is pending, and sweep lengths across every bin edge.

// File: rtl/stats_pkg.sv
// Shared constants and index decoding for the per-port statistics bank.
// Assumes the sparse index map: 0x00..0x1F direct, 0x80..0x83 totals.
package stats_pkg;
    localparam int RX_EVT_N = 13;
    localparam int BIN_N    = 8;
    localparam int TX_EVT_N = 11;
    localparam int DIRECT_N = RX_EVT_N + BIN_N + TX_EVT_N;
    localparam int EXT_N    = 4;
    localparam int SLOT_N   = DIRECT_N + EXT_N;
    localparam int SLOT_W   = $clog2(SLOT_N);
    localparam int BIN_BASE = RX_EVT_N;
    localparam int TX_BASE  = RX_EVT_N + BIN_N;
    localparam int SL_RX_BYTES = DIRECT_N;
    localparam int SL_TX_BYTES = DIRECT_N + 1;
    localparam int SL_RX_DROP  = DIRECT_N + 2;
    localparam int SL_TX_DROP  = DIRECT_N + 3;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
    } slot_sel_t;

    // Translate an 8-bit counter index into a storage slot.
    function automatic slot_sel_t map_index(input logic [7:0] idx);
        slot_sel_t r;
        r.hit  = (idx[7:5] == 3'b000) || (idx[7:2] == 6'b100000);
        r.slot = idx[7] ? SLOT_W'(DIRECT_N + int'(idx[1:0]))
                        : SLOT_W'(idx[4:0]);
        return r;
    endfunction

    // Pick the size bin (0..7) for a frame length.
    function automatic int size_bin(input int len);
        if (len <= 64)        return 0;
        else if (len <= 127)  return 1;
        else if (len <= 255)  return 2;
        else if (len <= 511)  return 3;
        else if (len <= 1023) return 4;
        else if (len <= 1522) return 5;
        else if (len <= 2000) return 6;
        return 7;
    endfunction
endpackage

// File: rtl/stats_cnt_cell.sv
// One saturating counter. On clr the old value is discarded and only the
// increment of this cycle is kept. Assumes INC_W >= 1.
module stats_cnt_cell #(
    parameter int CNT_W = 32,
    parameter int INC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;

    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] nxt;

    // Form the saturated next value from the kept base plus increment.
    always_comb begin
        base = clr ? '0 : SUM_W'(cnt);
        sum  = base + SUM_W'(inc);
        nxt  = (|sum[SUM_W-1:CNT_W]) ? '1 : sum[CNT_W-1:0];
    end

    // Register the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end
endmodule

// File: rtl/stats_evt_decode.sv
// Turns MAC event pulses and frame lengths into a per-slot increment amount.
// Assumes all inputs are single-cycle pulses qualified by the clock.
module stats_evt_decode
    import stats_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [RX_EVT_N-1:0]          rx_evt,
    input  logic [TX_EVT_N-1:0]          tx_evt,
    input  logic                         rx_drop,
    input  logic                         tx_drop,
    input  logic                         rx_done,
    input  logic [LEN_W-1:0]             rx_len,
    input  logic                         tx_done,
    input  logic [LEN_W-1:0]             tx_len,
    output logic [SLOT_N-1:0][LEN_W-1:0] inc_amt
);
    int bin_sel;

    // Route each event source to its slot.
    always_comb begin
        inc_amt = '0;
        for (int i = 0; i < RX_EVT_N; i++) inc_amt[i] = LEN_W'(rx_evt[i]);
        for (int j = 0; j < TX_EVT_N; j++) inc_amt[TX_BASE + j] = LEN_W'(tx_evt[j]);
        bin_sel = size_bin(int'(rx_len));
        inc_amt[BIN_BASE + bin_sel] = LEN_W'(rx_done);
        inc_amt[SL_RX_BYTES] = rx_done ? rx_len : '0;
        inc_amt[SL_TX_BYTES] = tx_done ? tx_len : '0;
        inc_amt[SL_RX_DROP]  = LEN_W'(rx_drop);
        inc_amt[SL_TX_DROP]  = LEN_W'(tx_drop);
    end
endmodule

// File: rtl/stats_rd_ctrl.sv
// Command register handshake: accepts a read request when idle, holds busy
// for one cycle while the snapshot is taken. Writes while busy are dropped.
module stats_rd_ctrl
    import stats_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic [7:0]        cmd_idx,
    output logic              busy,
    output logic              cap_hit,
    output logic [SLOT_W-1:0] cap_slot
);
    logic      accept;
    slot_sel_t sel;

    // Decide whether this command write starts a read.
    always_comb begin
        accept = cmd_wr && cmd_rd && !busy;
        sel    = map_index(cmd_idx);
    end

    // Track busy and latch the decoded target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cap_hit  <= 1'b0;
            cap_slot <= '0;
        end else begin
            busy <= accept;
            if (accept) begin
                cap_hit  <= sel.hit;
                cap_slot <= sel.slot;
            end
        end
    end
endmodule

// File: rtl/stats_bank.sv
// Per-port statistics counter bank: event decode, saturating counter array,
// and a read-and-clear snapshot path. Assumes one port and one reader.
module stats_bank
    import stats_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [12:0]         rx_evt,
    input  logic [10:0]         tx_evt,
    input  logic                rx_drop,
    input  logic                tx_drop,
    input  logic                rx_done,
    input  logic [LEN_W-1:0]    rx_len,
    input  logic                tx_done,
    input  logic [LEN_W-1:0]    tx_len,
    input  logic                cmd_wr,
    input  logic                cmd_rd,
    input  logic [7:0]          cmd_idx,
    output logic                cmd_busy,
    output logic [CNT_W-1:0]    rd_data
);
    logic [SLOT_N-1:0][LEN_W-1:0] inc_amt;
    logic [CNT_W-1:0]             cnt_q [SLOT_N];
    logic                         cap_hit;
    logic [SLOT_W-1:0]            cap_slot;

    stats_evt_decode #(.LEN_W(LEN_W)) dec_i (
        .rx_evt (rx_evt),
        .tx_evt (tx_evt),
        .rx_drop(rx_drop),
        .tx_drop(tx_drop),
        .rx_done(rx_done),
        .rx_len (rx_len),
        .tx_done(tx_done),
        .tx_len (tx_len),
        .inc_amt(inc_amt)
    );

    stats_rd_ctrl ctl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (cmd_wr),
        .cmd_rd  (cmd_rd),
        .cmd_idx (cmd_idx),
        .busy    (cmd_busy),
        .cap_hit (cap_hit),
        .cap_slot(cap_slot)
    );

    for (genvar s = 0; s < SLOT_N; s++) begin : g_cnt
        logic clr_s;
        // Clear this slot when it is the snapshot target.
        always_comb clr_s = cmd_busy && cap_hit && (cap_slot == SLOT_W'(s));
        stats_cnt_cell #(.CNT_W(CNT_W), .INC_W(LEN_W)) cell_i (
            .clk  (clk),
            .rst_n(rst_n),
            .inc  (inc_amt[s]),
            .clr  (clr_s),
            .cnt  (cnt_q[s])
        );
    end

    // Capture the selected counter, or zero for an undefined index.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_data <= '0;
        else if (cmd_busy) rd_data <= cap_hit ? cnt_q[cap_slot] : '0;
    end
endmodule

// File: rtl/stats_bank_chk.sv
// Protocol checker for stats_bank, attached by bind. Observes ports only.
module stats_bank_chk
    import stats_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_wr,
    input logic             cmd_rd,
    input logic [7:0]       cmd_idx,
    input logic             cmd_busy,
    input logic [CNT_W-1:0] rd_data
);
    logic [7:0] idx_seen;

    // Remember the index of the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)                             idx_seen <= '0;
        else if (cmd_wr && cmd_rd && !cmd_busy) idx_seen <= cmd_idx;
    end

    logic idx_defined;
    always_comb idx_defined = (idx_seen < 8'h20) || (idx_seen >= 8'h80 && idx_seen <= 8'h83);

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_rd && !cmd_busy) |=> cmd_busy); // R6
    AST_IGNORED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmd_wr && cmd_rd) && !cmd_busy) |=> !cmd_busy); // R6
    AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> !cmd_busy); // R7
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_busy |=> $stable(rd_data)); // R7
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && !idx_defined) |=> (rd_data == '0)); // R5
endmodule

bind stats_bank stats_bank_chk #(.CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (cmd_wr),
    .cmd_rd  (cmd_rd),
    .cmd_idx (cmd_idx),
    .cmd_busy(cmd_busy),
    .rd_data (rd_data)
);

// File: tb/stats_bank_tb_top.sv
module stats_bank_tb_top;
    localparam int CNT_W = 12;
    localparam int LEN_W = 11;
    localparam int MAXV  = (1 << CNT_W) - 1;
    localparam int NS    = 36;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [12:0]      rx_evt = '0;
    logic [10:0]      tx_evt = '0;
    logic             rx_drop = 1'b0, tx_drop = 1'b0;
    logic             rx_done = 1'b0, tx_done = 1'b0;
    logic [LEN_W-1:0] rx_len = '0, tx_len = '0;
    logic             cmd_wr = 1'b0, cmd_rd = 1'b0;
    logic [7:0]       cmd_idx = '0;
    logic             cmd_busy;
    logic [CNT_W-1:0] rd_data;

    int  n_chk = 0, n_fail = 0;
    bit  finished = 0;
    int  model [NS];
    bit  pend = 0;
    int  pend_idx = 0;

    always #4 clk = ~clk;

    stats_bank #(.CNT_W(CNT_W), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .tx_evt(tx_evt),
        .rx_drop(rx_drop), .tx_drop(tx_drop), .rx_done(rx_done), .rx_len(rx_len),
        .tx_done(tx_done), .tx_len(tx_len), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
        .cmd_idx(cmd_idx), .cmd_busy(cmd_busy), .rd_data(rd_data)
    );

    function automatic int slot_of(int idx);
        if (idx >= 0 && idx < 32) return idx;
        if (idx >= 128 && idx <= 131) return 32 + idx - 128;
        return -1;
    endfunction

    function automatic int bin_of(int len);
        if (len <= 64) return 0;
        if (len <= 127) return 1;
        if (len <= 255) return 2;
        if (len <= 511) return 3;
        if (len <= 1023) return 4;
        if (len <= 1522) return 5;
        if (len <= 2000) return 6;
        return 7;
    endfunction

    function automatic string tag_of(int idx);
        if (idx < 13) return "R1";
        if (idx < 21) return "R2";
        if (idx < 32) return "R3";
        if (idx >= 128 && idx <= 131) return "R4";
        return "R5";
    endfunction

    function automatic int sat(int v);
        return (v > MAXV) ? MAXV : v;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        rx_evt = '0; tx_evt = '0; rx_drop = 0; tx_drop = 0;
        rx_done = 0; tx_done = 0; rx_len = '0; tx_len = '0;
    endtask

    task automatic rand_events();
        rx_evt  = 13'($urandom & $urandom);
        tx_evt  = 11'($urandom & $urandom);
        rx_drop = ($urandom_range(0, 7) == 0);
        tx_drop = ($urandom_range(0, 7) == 0);
        rx_done = ($urandom_range(0, 3) == 0);
        tx_done = ($urandom_range(0, 3) == 0);
        rx_len  = LEN_W'($urandom_range(0, 2047));
        tx_len  = LEN_W'($urandom_range(0, 2047));
    endtask

    // One clock edge: model the edge, apply it, check busy and data.
    task automatic step();
        int  inc [NS];
        bit  done;
        int  e, s, old_idx, prev;
        bit  acc;
        for (int k = 0; k < NS; k++) inc[k] = 0;
        for (int i = 0; i < 13; i++) inc[i] += int'(rx_evt[i]);
        for (int j = 0; j < 11; j++) inc[21 + j] += int'(tx_evt[j]);
        if (rx_done) begin
            inc[13 + bin_of(int'(rx_len))] += 1;
            inc[32] += int'(rx_len);
        end
        if (tx_done) inc[33] += int'(tx_len);
        inc[34] += int'(rx_drop);
        inc[35] += int'(tx_drop);
        done = pend; e = 0; old_idx = pend_idx;
        if (pend) begin
            s = slot_of(pend_idx);
            if (s >= 0) begin e = model[s]; model[s] = 0; end
        end
        for (int k = 0; k < NS; k++) model[k] = sat(model[k] + inc[k]);
        acc  = cmd_wr && cmd_rd && !pend;
        prev = int'(rd_data);
        @(posedge clk);
        @(negedge clk);
        pend = acc;
        if (acc) pend_idx = int'(cmd_idx);
        chk(cmd_busy === pend, "R6 busy", int'(cmd_busy), int'(pend));
        if (done) chk(int'(rd_data) == e, tag_of(old_idx), int'(rd_data), e);
        else      chk(int'(rd_data) == prev, "R7 data held", int'(rd_data), prev);
    endtask

    // Full read with quiet events; result left on rd_data.
    task automatic rd(int idx);
        quiet();
        cmd_wr = 1; cmd_rd = 1; cmd_idx = 8'(idx);
        step();
        cmd_wr = 0; cmd_rd = 0;
        step();
    endtask

    initial begin
        int lens [14] = '{64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1522, 1523, 2000, 2001};
        void'($urandom(32'd20240611));
        for (int k = 0; k < NS; k++) model[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(cmd_busy === 1'b0, "R11 busy", int'(cmd_busy), 0);
        chk(rd_data === '0, "R11 data", int'(rd_data), 0);
        rd(8'h0C); chk(int'(rd_data) == 0, "R11 cnt", int'(rd_data), 0);
        rd(8'h80); chk(int'(rd_data) == 0, "R11 cnt", int'(rd_data), 0);

        // R6: write without read bit is ignored
        rx_evt = 13'h1; step(); quiet();
        cmd_wr = 1; cmd_rd = 0; cmd_idx = 8'h00; step();
        cmd_wr = 0;
        chk(cmd_busy === 1'b0, "R6 no-read", int'(cmd_busy), 0);
        rd(8'h00); chk(int'(rd_data) == 1, "R6 counter kept", int'(rd_data), 1);

        // R8: read clears
        tx_evt = 11'h008; repeat (4) step(); quiet();
        rd(8'h18); chk(int'(rd_data) == 4, "R3", int'(rd_data), 4);
        rd(8'h18); chk(int'(rd_data) == 0, "R8", int'(rd_data), 0);

        // R9: increment in the snapshot cycle is kept
        rx_evt = 13'h020; repeat (3) step(); quiet();
        cmd_wr = 1; cmd_rd = 1; cmd_idx = 8'h05; step();
        cmd_wr = 0; cmd_rd = 0; rx_evt = 13'h020; step(); quiet();
        chk(int'(rd_data) == 3, "R9 snapshot", int'(rd_data), 3);
        rd(8'h05); chk(int'(rd_data) == 1, "R9", int'(rd_data), 1);

        // R6: write while busy dropped
        rx_drop = 1; step(); quiet();
        cmd_wr = 1; cmd_rd = 1; cmd_idx = 8'h82; step();
        cmd_idx = 8'h00; step();
        cmd_wr = 0; cmd_rd = 0; step();
        chk(cmd_busy === 1'b0, "R6 busy write", int'(cmd_busy), 0);
        chk(int'(rd_data) == 1, "R4 drop", int'(rd_data), 1);

        // R5: undefined indices
        rd(8'h20); rd(8'h40); rd(8'h84); rd(8'hFF);
        chk(int'(rd_data) == 0, "R5", int'(rd_data), 0);

        // R2: bin boundaries, one frame each
        foreach (lens[i]) begin
            quiet(); rx_done = 1; rx_len = LEN_W'(lens[i]); step();
        end
        quiet();
        for (int b = 13; b < 21; b++) begin
            rd(b);
            chk(int'(rd_data) == ((b == 13 || b == 20) ? 1 : 2), "R2 bin", int'(rd_data),
                (b == 13 || b == 20) ? 1 : 2);
        end
        rd(8'h80);

        // R10: saturation of an event counter and a byte total
        rx_evt = 13'h001; repeat (MAXV + 100) step(); quiet();
        rd(8'h00); chk(int'(rd_data) == MAXV, "R10 event", int'(rd_data), MAXV);
        tx_done = 1; tx_len = 11'd2047; repeat (3) step(); quiet();
        rd(8'h81); chk(int'(rd_data) == MAXV, "R10 bytes", int'(rd_data), MAXV);

        // Random traffic with interleaved reads
        for (int n = 0; n < 4000; n++) begin
            rand_events();
            if (!pend && $urandom_range(0, 5) == 0) begin
                cmd_wr = 1; cmd_rd = ($urandom_range(0, 4) != 0);
                case ($urandom_range(0, 2))
                    0: cmd_idx = 8'($urandom_range(0, 31));
                    1: cmd_idx = 8'($urandom_range(128, 131));
                    default: cmd_idx = 8'($urandom);
                endcase
            end else begin
                cmd_wr = ($urandom_range(0, 9) == 0); cmd_rd = 1; cmd_idx = 8'($urandom);
            end
            step();
            cmd_wr = 0; cmd_rd = 0;
        end
        quiet(); step();
        for (int k = 0; k < 32; k++) rd(k);
        for (int k = 128; k < 132; k++) rd(k);

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R7 actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule